// File: doc/BRIEF.md
# Frame Alignment Controller

This block finds and holds the start-of-frame position in a continuous byte stream whose frames all have the same length. A separate pattern detector samples the stream and raises a one-bit hit flag once per byte whenever it sees the framing pattern. The controller turns those hits into a lock decision.

A first hit while hunting opens a candidate alignment and restarts a position counter. The controller then waits exactly one frame period. If a second hit arrives at the predicted slot, it declares lock. If the hit is missing, it drops the candidate and resumes hunting. While locked, every frame must show a hit at the predicted slot, or the lock is lost.

Each accepted slot hit produces a one-cycle start-of-frame strobe. The current state is exported for debug, together with a locked level. The frame length is a parameter, and the counter width is derived from it.

Top module: `frame_lock_ctrl`

## Requirements
- R1: `state_dbg` shows HUNT as 2'b00, VERIFY as 2'b01 and LOCK as 2'b10; the value 2'b11 never appears.
- R2: While `rst_n` is low, `state_dbg` is HUNT and `sof_pulse` and `locked` are low. This takes effect at once, without waiting for a clock edge. The position counter is cleared.
- R3: In HUNT, a high `sync_hit` moves the state to VERIFY at the next edge and restarts the position count. The predicted slot is then the cycle exactly FRAME_LEN cycles after that hit, and every FRAME_LEN cycles after that.
- R4: In VERIFY, a high `sync_hit` in the predicted slot moves the state to LOCK.
- R5: In VERIFY, a low `sync_hit` in the predicted slot returns the state to HUNT.
- R6: In LOCK, a high `sync_hit` in the predicted slot keeps LOCK, and a low one returns the state to HUNT.
- R7: In VERIFY and LOCK, `sync_hit` in any cycle other than the predicted slot leaves the state and the slot timing unchanged.
- R8: `sof_pulse` is high for exactly one cycle, namely the cycle after a high `sync_hit` in the predicted slot while in VERIFY or LOCK. `locked` is high exactly when the state is LOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_hit | input | 1 | Framing pattern seen on the current byte |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| state_dbg | output | 2 | Current controller state (HUNT/VERIFY/LOCK) |
| locked | output | 1 | High while aligned |

## Verification
A wrong state or a slipped position counter shows up as a mismatch on `state_dbg` one edge after the predicted slot. At that point an expected lock fails to appear, or a hold turns into a drop. Ignored off-slot hits are checked by watching `state_dbg` remain unchanged over whole frame periods. A correct lock or drop exactly FRAME_LEN cycles later proves the slot timing was untouched. A misplaced or repeated strobe appears on `sof_pulse` in the cycle right after the slot.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'b00,
      ST_VERIFY = 2'b01,
      ST_LOCK   = 2'b10
   } lock_state_t;

   function automatic int pos_width(input int frame_len);
      return (frame_len <= 2) ? 1 : $clog2(frame_len);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/frame_pos_ctr.sv
module frame_pos_ctr
   import frame_lock_pkg::*;
#(
   parameter int FRAME_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic at_slot
);
   localparam int W = pos_width(FRAME_LEN);
   localparam logic [W-1:0] LAST = W'(FRAME_LEN - 1);

   logic [W-1:0] pos_q;

   generate
      if (is_pow2(FRAME_LEN)) begin : g_natural_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pos_q <= '0;
            else if (restart) pos_q <= '0;
            else              pos_q <= pos_q + 1'b1;
         end
         assign at_slot = &pos_q;
      end else begin : g_compare_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pos_q <= '0;
            else if (restart)        pos_q <= '0;
            else if (pos_q == LAST)  pos_q <= '0;
            else                     pos_q <= pos_q + 1'b1;
         end
         assign at_slot = (pos_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/frame_lock_fsm.sv
module frame_lock_fsm
   import frame_lock_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sync_hit,
   input  logic        at_slot,
   output lock_state_t state,
   output logic        restart,
   output logic        accept
);
   lock_state_t state_d;

   always_comb begin
      state_d = state;
      unique case (state)
         ST_HUNT:   if (sync_hit) state_d = ST_VERIFY;
         ST_VERIFY: if (at_slot)  state_d = sync_hit ? ST_LOCK : ST_HUNT;
         ST_LOCK:   if (at_slot)  state_d = sync_hit ? ST_LOCK : ST_HUNT;
         default:                 state_d = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_HUNT;
      else        state <= state_d;
   end

   assign restart = (state == ST_HUNT) && sync_hit;
   assign accept  = (state != ST_HUNT) && at_slot && sync_hit;

endmodule

// File: rtl/frame_sof_reg.sv
module frame_sof_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   output logic sof_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sof_pulse <= 1'b0;
      else        sof_pulse <= accept;
   end
endmodule

// File: rtl/frame_lock_ctrl.sv
module frame_lock_ctrl
   import frame_lock_pkg::*;
#(
   parameter int FRAME_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_hit,
   output logic       sof_pulse,
   output logic [1:0] state_dbg,
   output logic       locked
);
   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("frame_lock_ctrl: FRAME_LEN must be at least 2");
      end
   endgenerate

   lock_state_t state;
   logic        at_slot;
   logic        restart;
   logic        accept;

   frame_pos_ctr #(.FRAME_LEN(FRAME_LEN)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .at_slot (at_slot)
   );

   frame_lock_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_hit (sync_hit),
      .at_slot  (at_slot),
      .state    (state),
      .restart  (restart),
      .accept   (accept)
   );

   frame_sof_reg u_sof (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .sof_pulse (sof_pulse)
   );

   assign state_dbg = state;
   assign locked    = (state == ST_LOCK);

endmodule

// File: rtl/frame_lock_chk.sv
module frame_lock_chk #(
   parameter int FRAME_LEN = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sync_hit,
   input logic       sof_pulse,
   input logic [1:0] state_dbg,
   input logic       locked
);
   localparam int CW = (FRAME_LEN <= 2) ? 1 : $clog2(FRAME_LEN);
   localparam logic [CW-1:0] CLAST = CW'(FRAME_LEN - 1);

   logic [CW-1:0] cpos;
   logic          cslot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cpos <= '0;
      else if (state_dbg == 2'b00 && sync_hit)   cpos <= '0;
      else if (cpos == CLAST)                    cpos <= '0;
      else                                       cpos <= cpos + 1'b1;
   end
   assign cslot = (cpos == CLAST);

   a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
      state_dbg != 2'b11);

   a_r3_enter_verify: assert property (@(posedge clk) disable iff (!rst_n)
      (state_dbg == 2'b00 && sync_hit) |=> (state_dbg == 2'b01));

   a_r4_verify_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (state_dbg == 2'b01 && cslot && sync_hit) |=> (state_dbg == 2'b10));

   a_r5_verify_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_dbg == 2'b01 && cslot && !sync_hit) |=> (state_dbg == 2'b00));

   a_r6_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_dbg == 2'b10 && cslot && !sync_hit) |=> (state_dbg == 2'b00));

   a_r7_offslot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_dbg != 2'b00 && !cslot) |=> $stable(state_dbg));

   a_r8_sof_locked: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |-> locked);

   a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |=> !sof_pulse);

endmodule

bind frame_lock_ctrl frame_lock_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_hit  (sync_hit),
   .sof_pulse (sof_pulse),
   .state_dbg (state_dbg),
   .locked    (locked)
);

// File: tb/sim_frame_lock_ctrl.sv
`timescale 1ns/1ps
module sim_frame_lock_ctrl;
   localparam int L = 6;
   localparam int NV = 28;
   // entry = {sync_hit, expected state after edge [1:0], expected sof}
   localparam logic [3:0] VEC [0:NV-1] = '{
      4'b0000, 4'b1010, 4'b1010, 4'b0010, 4'b1010, 4'b0010, 4'b0010,
      4'b1101, 4'b1100, 4'b0100, 4'b1100, 4'b0100, 4'b1100, 4'b1101,
      4'b0100, 4'b1100, 4'b0100, 4'b0100, 4'b0100, 4'b0000, 4'b1010,
      4'b0010, 4'b1010, 4'b0010, 4'b0010, 4'b1010, 4'b0000, 4'b0000
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sync_hit;
   logic       sof_pulse;
   logic [1:0] state_dbg;
   logic       locked;
   int         n_run = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   frame_lock_ctrl #(.FRAME_LEN(L)) u0 (
      .clk(clk), .rst_n(rst_n), .sync_hit(sync_hit),
      .sof_pulse(sof_pulse), .state_dbg(state_dbg), .locked(locked)
   );

   task automatic chk(input string req, input logic [1:0] st, input logic sof, input logic lk);
      n_run++;
      if (state_dbg !== st || sof_pulse !== sof || locked !== lk) begin
         n_fail++;
         $display("FAIL %s: state=%b sof=%b locked=%b, expected state=%b sof=%b locked=%b",
                  req, state_dbg, sof_pulse, locked, st, sof, lk);
      end
   endtask

   task automatic step(input logic hit, input logic [1:0] st, input logic sof, input string req);
      sync_hit = hit;
      @(posedge clk);
      @(negedge clk);
      chk(req, st, sof, st == 2'b10);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      sync_hit = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 reset state", 2'b00, 1'b0, 1'b0);
      rst_n = 1'b1;

      // R1 R3 R4 R5 R6 R7 R8 walked from the table
      for (int i = 0; i < NV; i++)
         step(VEC[i][3], VEC[i][2:1], VEC[i][0], "R3/R4/R5/R6/R7/R8 table");

      // R7: hits in every off-slot cycle during VERIFY are ignored
      step(1'b1, 2'b01, 1'b0, "R3 enter verify");
      for (int k = 0; k < L - 1; k++)
         step(1'b1, 2'b01, 1'b0, "R7 off-slot ignored");
      step(1'b1, 2'b10, 1'b1, "R4 lock at slot");

      // R2: asynchronous reset in LOCK, mid-cycle
      #5 rst_n = 1'b0;
      #1 chk("R2 async reset", 2'b00, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 2'b00, 1'b0, "R2 stays hunting");

      // R8: relock, strobe lasts one cycle
      step(1'b1, 2'b01, 1'b0, "R3 enter verify");
      for (int k = 0; k < L - 1; k++)
         step(1'b0, 2'b01, 1'b0, "R7 quiet wait");
      step(1'b1, 2'b10, 1'b1, "R8 strobe");
      step(1'b0, 2'b10, 1'b0, "R8 strobe one cycle");
      for (int k = 0; k < L - 2; k++)
         step(1'b0, 2'b10, 1'b0, "R6 hold off-slot");
      step(1'b1, 2'b10, 1'b1, "R6 keep lock");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule